// File: doc/BRIEF.md
# Relocatable Peripheral Page Decoder

This block sits on the external data memory bus of a small 8-bit controller. The bus has a 16-bit address, an 8-bit data path and separate read and write strobes. The block carves out one 256-byte window for an on-chip peripheral. It gives that peripheral a select, an 8-bit offset and qualified read and write strobes, and it steers the peripheral's read data back toward the CPU.

The window has no fixed location. An 8-bit base register supplies address bits 15:8 of the window start. Software reaches that register at the very top address of the space, FFFFh. After reset the base is 00h, so the window covers 0000h–00FFh. Writing 80h to FFFFh moves the window to 8000h–80FFh. Both the window and the base register live inside the chip. Any external memory decoded at the same addresses would fight them on the bus, so the block tells the bus logic when it is driving read data.

An access to FFFFh always goes to the base register, so the register stays reachable even when the window is placed at FF00h. The window then covers FF00h–FFFEh only.

Top module: `reloc_page_decoder`

## Requirements
- R1: While reset is held, and after it is released with no write, the base is 00h. A read of FFFFh returns 00h, and addresses 0000h–00FFh select the page.
- R2: `pg_sel` is 1 exactly when address bits 15:8 equal the current base and the address is not FFFFh. `pg_offset` always equals address bits 7:0.
- R3: A write strobe at FFFFh loads `cpu_wdata` into the base on the rising clock edge where it is sampled. Accesses presented in the cycle after that edge decode against the new base.
- R4: FFFFh has priority over the page. With base FFh, FF00h–FFFEh select the page and FFFFh does not.
- R5: A read of FFFFh drives `cpu_rdata` with the current base and sets `cpu_rdata_oe` to 1.
- R6: A read inside the page passes `pg_rdata` to `cpu_rdata` combinationally, with `cpu_rdata_oe` = 1 and `pg_rd` = 1.
- R7: Any read outside the page and not at FFFFh leaves `cpu_rdata_oe` at 0 and `cpu_rdata` at 00h.
- R8: Writes to any address other than FFFFh leave the base unchanged, and so do reads of FFFFh.
- R9: `pg_rd` and `pg_wr` are the page select qualified by `cpu_rd` and `cpu_wr`. With no read strobe, `cpu_rdata_oe` is 0 at every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU external data address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe, active high |
| cpu_wr | input | 1 | CPU write strobe, active high |
| cpu_rdata | output | 8 | Read data toward the CPU, 00h when not driving |
| cpu_rdata_oe | output | 1 | High when this block owns the read data bus |
| pg_sel | output | 1 | Address falls inside the peripheral page |
| pg_offset | output | 8 | Offset within the page |
| pg_rd | output | 1 | Read strobe for the peripheral |
| pg_wr | output | 1 | Write strobe for the peripheral |
| pg_rdata | input | 8 | Read data from the peripheral |

## Verification
The bench sweeps all 65536 addresses for bases 00h, 5Ah, 80h and FFh, and compares select, offset, output enable and read data against arithmetic from the address.

- The FFh base is the sharpest case. A decoder without the FFFFh priority would select the page at FFFFh and return peripheral data instead of the base.
- An off-by-one in the compare would light the neighbouring page.
- The relocation write is checked in the cycle right after its edge. A base that lagged a cycle, or that was loaded from non-top writes, would leave a stale window or a corrupted base, and reading FFFFh back exposes it.

// File: rtl/pgdec_pkg.sv
package pgdec_pkg;

  // Default geometry of the bus and the window.
  localparam int unsigned DEF_ADDR_W = 16;
  localparam int unsigned DEF_OFF_W  = 8;
  localparam int unsigned DEF_DATA_W = 8;

  // Result of the address decode, in priority order.
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_PAGE = 2'd1,
    HIT_BASE = 2'd2
  } hit_e;

endpackage

// File: rtl/pgdec_base_reg.sv
module pgdec_base_reg #(
  parameter int unsigned BASE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BASE_W-1:0] load_val,
  output logic [BASE_W-1:0] base_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (load) begin
      base_q <= load_val;
    end
  end

endmodule

// File: rtl/pgdec_match.sv
module pgdec_match
  import pgdec_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 8,
  localparam int unsigned BASE_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base,
  output hit_e              hit,
  output logic [OFF_W-1:0]  offset
);

  // Top of the address space holds the base register.
  function automatic logic at_top(input logic [ADDR_W-1:0] a);
    return &a;
  endfunction

  // High part of the address that names a page.
  function automatic logic [BASE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  always_comb begin
    if (at_top(addr)) begin
      hit = HIT_BASE;
    end else if (page_of(addr) == base) begin
      hit = HIT_PAGE;
    end else begin
      hit = HIT_NONE;
    end
  end

  assign offset = addr[OFF_W-1:0];

endmodule

// File: rtl/pgdec_rsteer.sv
module pgdec_rsteer #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BASE_W = 8
) (
  input  logic              rd,
  input  logic              reg_hit,
  input  logic              page_hit,
  input  logic [BASE_W-1:0] base,
  input  logic [DATA_W-1:0] page_data,
  output logic [DATA_W-1:0] rdata,
  output logic              oe
);

  logic [DATA_W-1:0] base_ext;

  generate
    if (BASE_W < DATA_W) begin : g_pad
      assign base_ext = {{(DATA_W - BASE_W){1'b0}}, base};
    end else begin : g_trim
      assign base_ext = base[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    rdata = '0;
    oe    = 1'b0;
    if (rd) begin
      if (reg_hit) begin
        rdata = base_ext;
        oe    = 1'b1;
      end else if (page_hit) begin
        rdata = page_data;
        oe    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/reloc_page_decoder.sv
module reloc_page_decoder
  import pgdec_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned OFF_W  = DEF_OFF_W,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rdata_oe,
  output logic              pg_sel,
  output logic [OFF_W-1:0]  pg_offset,
  output logic              pg_rd,
  output logic              pg_wr,
  input  logic [DATA_W-1:0] pg_rdata
);

  localparam int unsigned BASE_W = ADDR_W - OFF_W;

  // Named internal events, visible to the bound checker.
  hit_e              hit;
  logic              reg_hit;
  logic              page_hit;
  logic              base_load;
  logic [BASE_W-1:0] base_q;
  logic [BASE_W-1:0] base_wval;

  pgdec_match #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
  ) u_match (
    .addr   (cpu_addr),
    .base   (base_q),
    .hit    (hit),
    .offset (pg_offset)
  );

  assign reg_hit   = (hit == HIT_BASE);
  assign page_hit  = (hit == HIT_PAGE);
  assign base_load = reg_hit & cpu_wr;

  generate
    if (BASE_W <= DATA_W) begin : g_wnarrow
      assign base_wval = cpu_wdata[BASE_W-1:0];
    end else begin : g_wwide
      assign base_wval = {{(BASE_W - DATA_W){1'b0}}, cpu_wdata};
    end
  endgenerate

  pgdec_base_reg #(
    .BASE_W (BASE_W)
  ) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (base_load),
    .load_val (base_wval),
    .base_q   (base_q)
  );

  assign pg_sel = page_hit;
  assign pg_rd  = page_hit & cpu_rd;
  assign pg_wr  = page_hit & cpu_wr;

  pgdec_rsteer #(
    .DATA_W (DATA_W),
    .BASE_W (BASE_W)
  ) u_steer (
    .rd        (cpu_rd),
    .reg_hit   (reg_hit),
    .page_hit  (page_hit),
    .base      (base_q),
    .page_data (pg_rdata),
    .rdata     (cpu_rdata),
    .oe        (cpu_rdata_oe)
  );

endmodule

// File: rtl/pgdec_checker.sv
module pgdec_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned BASE_W = ADDR_W - OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              cpu_rdata_oe,
  input logic              pg_sel,
  input logic              pg_rd,
  input logic              pg_wr,
  input logic [BASE_W-1:0] base_q
);

  logic top_addr;
  assign top_addr = (cpu_addr == {ADDR_W{1'b1}});

  // R3: a top write lands in the base on the next edge
  p_base_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (top_addr && cpu_wr) |=> (base_q == $past(cpu_wdata[BASE_W-1:0])));

  // R8: nothing else moves the base
  p_base_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(top_addr && cpu_wr) |=> $stable(base_q));

  // R4: the top address never selects the page
  p_top_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    top_addr |-> !pg_sel);

  // R5: reading the top address returns the base
  p_base_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (top_addr && cpu_rd) |-> (cpu_rdata_oe && cpu_rdata[BASE_W-1:0] == base_q));

  // R7: outside both targets the data bus stays released
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pg_sel && !top_addr) |-> !cpu_rdata_oe);

  // R9: peripheral strobes only inside the page
  p_strobe_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_rd || pg_wr) |-> pg_sel);

  // R2: a selected page matches the base
  p_sel_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pg_sel |-> (cpu_addr[ADDR_W-1:OFF_W] == base_q));

endmodule

bind reloc_page_decoder pgdec_checker #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_addr     (cpu_addr),
  .cpu_wdata    (cpu_wdata),
  .cpu_rd       (cpu_rd),
  .cpu_wr       (cpu_wr),
  .cpu_rdata    (cpu_rdata),
  .cpu_rdata_oe (cpu_rdata_oe),
  .pg_sel       (pg_sel),
  .pg_rd        (pg_rd),
  .pg_wr        (pg_wr),
  .base_q       (base_q)
);

// File: tb/tb_reloc_page_decoder.sv
module tb_reloc_page_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        cpu_rdata_oe;
  logic        pg_sel;
  logic [7:0]  pg_offset;
  logic        pg_rd;
  logic        pg_wr;
  logic [7:0]  pg_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  reloc_page_decoder dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_rd       (cpu_rd),
    .cpu_wr       (cpu_wr),
    .cpu_rdata    (cpu_rdata),
    .cpu_rdata_oe (cpu_rdata_oe),
    .pg_sel       (pg_sel),
    .pg_offset    (pg_offset),
    .pg_rd        (pg_rd),
    .pg_wr        (pg_wr),
    .pg_rdata     (pg_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Peripheral data pattern, distinct from the base values used.
  function automatic logic [7:0] pdata(input logic [15:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  // Read FFFFh and compare with the expected base.
  task automatic read_base(input logic [7:0] exp, input string req);
    cpu_wr = 1'b0;
    cpu_rd = 1'b1;
    cpu_addr = 16'hFFFF;
    #1;
    chk(cpu_rdata_oe && cpu_rdata == exp, req, {23'd0, cpu_rdata_oe, cpu_rdata},
        {24'd1, exp});
  endtask

  // Full address sweep for a known base.
  task automatic sweep(input logic [7:0] b);
    cpu_wr = 1'b0;
    cpu_rd = 1'b1;
    for (int a = 0; a < 65536; a++) begin
      logic [15:0] ad;
      logic        top, inp, e_oe;
      logic [7:0]  e_dat;
      ad = a[15:0];
      cpu_addr = ad;
      pg_rdata = pdata(ad);
      #1;
      top   = (a == 65535);
      inp   = !top && ((a / 256) == int'(b));
      e_oe  = top || inp;
      e_dat = top ? b : (inp ? pdata(ad) : 8'h00);
      if (top)
        chk(!pg_sel && cpu_rdata_oe && cpu_rdata == e_dat && !pg_rd, "R4 R5",
            {pg_sel, pg_rd, cpu_rdata_oe, cpu_rdata}, {3'b001, e_dat});
      else if (inp)
        chk(pg_sel && pg_rd && !pg_wr && cpu_rdata_oe && cpu_rdata == e_dat &&
            pg_offset == ad[7:0], "R2 R6",
            {pg_sel, pg_rd, cpu_rdata_oe, cpu_rdata, pg_offset}, {3'b111, e_dat, ad[7:0]});
      else
        chk(!pg_sel && !pg_rd && !cpu_rdata_oe && cpu_rdata == 8'h00 &&
            pg_offset == ad[7:0], "R2 R7",
            {pg_sel, pg_rd, cpu_rdata_oe, cpu_rdata, pg_offset}, {11'd0, ad[7:0]});
    end
  endtask

  // Write a new base; check the window in the very next cycle.
  task automatic relocate(input logic [7:0] b);
    @(negedge clk);
    cpu_rd = 1'b0;
    cpu_addr = 16'hFFFF;
    cpu_wdata = b;
    cpu_wr = 1'b1;
    @(posedge clk);
    #2;
    cpu_wr = 1'b0;
    cpu_rd = 1'b1;
    cpu_addr = {b, 8'h05};
    #1;
    chk(pg_sel == 1'b1 && (b == 8'hFF || cpu_rdata_oe), "R3 new base next cycle",
        {31'd0, pg_sel}, 32'd1);
    read_base(b, "R3 base readback");
  endtask

  initial begin
    // R1: state during and after reset
    cpu_rd = 1'b1;
    cpu_addr = 16'hFFFF;
    #5;
    chk(cpu_rdata_oe && cpu_rdata == 8'h00, "R1 in reset", {23'd0, cpu_rdata_oe, cpu_rdata}, 32'h100);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_base(8'h00, "R1 after reset");
    cpu_addr = 16'h0042;
    #1;
    chk(pg_sel && pg_offset == 8'h42, "R1 page at 0000h", {23'd0, pg_sel, pg_offset}, 32'h142);
    cpu_addr = 16'h0100;
    #1;
    chk(!pg_sel, "R1 0100h outside", {31'd0, pg_sel}, 32'd0);

    sweep(8'h00);

    // R3: address 8005h unselected before the move
    cpu_addr = 16'h8005;
    #1;
    chk(!pg_sel, "R3 before write", {31'd0, pg_sel}, 32'd0);
    relocate(8'h80);
    sweep(8'h80);
    relocate(8'h5A);
    sweep(8'h5A);
    relocate(8'hFF);
    sweep(8'hFF);

    // R8: writes at many other addresses, plus reads of FFFFh, keep the base
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      cpu_rd = 1'b0;
      cpu_wr = 1'b1;
      cpu_addr = 16'((k * 217) % 65535);
      cpu_wdata = 8'(k);
      #1;
      chk(pg_wr == (cpu_addr[15:8] == 8'hFF) && !cpu_rdata_oe, "R9 write strobe",
          {30'd0, pg_wr, cpu_rdata_oe}, {30'd0, cpu_addr[15:8] == 8'hFF, 1'b0});
    end
    @(negedge clk);
    cpu_wr = 1'b0;
    cpu_rd = 1'b1;
    cpu_addr = 16'hFFFF;
    repeat (3) @(negedge clk);
    read_base(8'hFF, "R8 base kept");

    // R9: no read strobe, no bus drive anywhere
    cpu_rd = 1'b0;
    for (int a = 0; a < 65536; a += 97) begin
      cpu_addr = a[15:0];
      #1;
      chk(!cpu_rdata_oe && !pg_rd && !pg_wr, "R9 idle strobes",
          {29'd0, cpu_rdata_oe, pg_rd, pg_wr}, 32'd0);
    end
    cpu_addr = 16'hFFFF;
    #1;
    chk(!cpu_rdata_oe, "R9 idle top", {31'd0, cpu_rdata_oe}, 32'd0);

    // R4: back to 00h, then check the top page edges at base FFh again
    relocate(8'h00);
    relocate(8'hFF);
    cpu_addr = 16'hFFFE;
    #1;
    chk(pg_sel && pg_offset == 8'hFE, "R4 FFFEh in page", {23'd0, pg_sel, pg_offset}, 32'h1FE);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule